// File: doc/BRIEF.md
# Port Link State Controller

This block holds the logical state of a single link-layer port and turns that state into four traffic enables. The enables cover generated and received link packets, management packets, outgoing data and incoming data. The rest of the link layer keeps a packet class flowing only while its enable is high. When an enable is low, packets of that class are discarded, and no link packets are generated.

The block's inputs are:
- a physical-link-up flag;
- a two-bit management command;
- single-cycle event pulses produced by the receive checkers;
- a down-timeout level.

The events report three things:
- a checked flow-control link packet with the initialize opcode arrived from the far end;
- a checked flow-control link packet with the normal opcode arrived;
- a non-management data packet arrived and passed its variant CRC check.

The step into Active takes two stages. A normal flow-control link packet seen in Arm or Active sets an internal permission latch. A later qualified data packet then triggers the move. The permission is lost whenever the port falls back to Initialize or Down. Every input is a plain level or pulse with no handshake, and the outputs come straight from the state register.

Top module: `port_link_ctrl`

## Requirements
- R1: While `rst_n` is low the state is Initialize (`port_state` = 2'b01), with only the link-packet and management enables high.
- R2: `port_state` encodes Down=00, Initialize=01, Arm=10, Active=11. The enables by state are as follows. Down: all low. Initialize: link and mgmt high. Arm: link, mgmt and data receive high. Active: all four high.
- R3: When `phy_up` is low at a clock edge, the next state is Down, whatever other inputs are present. The port stays Down while `phy_up` remains low.
- R4: From Down, the port moves to Initialize on the next edge once `phy_up` is high, the command is not Down (01), and `down_timeout` is low.
- R5: A management command of Down (`mgmt_cmd` = 01) moves any state to Down on the next edge.
- R6: A high `down_timeout` moves any state to Down on the next edge.
- R7: In Initialize, the command Arm (`mgmt_cmd` = 10) moves the port to Arm. Data, normal flow-control and remote-init events have no effect on the state in Initialize.
- R8: In Arm, a data event does not reach Active unless an earlier normal flow-control event has set the permission latch. A flow-control event and a data event in the same cycle do not move the port, but the latch is set.
- R9: In Arm with the latch set, a data event moves the port to Active on the next edge. The command Active (11) on its own never moves the port.
- R10: A remote-init event in Arm or Active returns the port to Initialize on the next edge, unless a Down condition is present in the same cycle.
- R11: The permission latch clears whenever the port leaves Arm/Active. After the port re-enters Arm, it needs a new normal flow-control event before a data event can take it to Active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_up | input | 1 | Physical link is up |
| mgmt_cmd | input | 2 | Management request: 00 none, 01 Down, 10 Arm, 11 Active |
| ev_remote_init | input | 1 | Checked flow-control init link packet received (pulse) |
| ev_fc_normal | input | 1 | Checked flow-control normal link packet received (pulse) |
| ev_data_ok | input | 1 | Non-management data packet passed variant CRC (pulse) |
| down_timeout | input | 1 | Down timeout expired |
| port_state | output | 2 | Current logical port state |
| en_link_pkt | output | 1 | Link packet generation/reception enabled |
| en_mgmt_pkt | output | 1 | Management packet traffic enabled |
| en_data_tx | output | 1 | Data packet transmit enabled |
| en_data_rx | output | 1 | Data packet receive enabled |

## Verification
The directed patterns are chosen to tell the Arm-to-Active ordering cases apart:
- a data event with no prior flow-control event;
- both events in the same cycle;
- a flow-control event followed by a data event;
- a lone Active command.

Re-entering Arm after a remote-init or a timeout shows whether the permission latch survived when it should have cleared. Down conditions are applied from every state, and together with a remote-init event in the same cycle, to expose any wrong priority. A long weighted random stream then exercises every transition against the behavioural model on each clock.

// File: rtl/plink_pkg.sv
package plink_pkg;
  localparam int ST_W  = 2;
  localparam int CMD_W = 2;
  localparam int EN_W  = 4;

  typedef enum logic [ST_W-1:0] {
    PS_DOWN   = 2'b00,
    PS_INIT   = 2'b01,
    PS_ARM    = 2'b10,
    PS_ACTIVE = 2'b11
  } pstate_e;

  typedef enum logic [CMD_W-1:0] {
    MC_NONE   = 2'b00,
    MC_DOWN   = 2'b01,
    MC_ARM    = 2'b10,
    MC_ACTIVE = 2'b11
  } mcmd_e;
endpackage

// File: rtl/plink_fsm.sv
module plink_fsm
  import plink_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    phy_up,
  input  mcmd_e   cmd,
  input  logic    ev_remote_init,
  input  logic    ev_fc_normal,
  input  logic    ev_data_ok,
  input  logic    down_timeout,
  output pstate_e state_q,
  output logic    act_en_q
);
  pstate_e state_d;
  logic    act_en_d;
  logic    drop;
  logic    live_d;

  assign drop = !phy_up || (cmd == MC_DOWN) || down_timeout;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_DOWN:   state_d = PS_INIT;
      PS_INIT:   if (cmd == MC_ARM) state_d = PS_ARM;
      PS_ARM: begin
        if (ev_remote_init)              state_d = PS_INIT;
        else if (act_en_q && ev_data_ok) state_d = PS_ACTIVE;
      end
      PS_ACTIVE: if (ev_remote_init) state_d = PS_INIT;
      default:   state_d = PS_DOWN;
    endcase
    if (drop) state_d = PS_DOWN;
  end

  assign live_d = (state_d == PS_ARM) || (state_d == PS_ACTIVE);

  always_comb begin
    act_en_d = act_en_q;
    if (((state_q == PS_ARM) || (state_q == PS_ACTIVE)) && ev_fc_normal)
      act_en_d = 1'b1;
    if (!live_d) act_en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PS_INIT;
      act_en_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      act_en_q <= act_en_d;
    end
  end

  // R3
  p_phy_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_up |=> state_q == PS_DOWN);
  // R5
  p_down_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == MC_DOWN |=> state_q == PS_DOWN);
  // R6
  p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
    down_timeout |=> state_q == PS_DOWN);
  // R9: Active is entered from Arm only with prior latch and a data event
  p_active_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_ARM ##1 state_q == PS_ACTIVE) |-> ($past(ev_data_ok) && $past(act_en_q)));
  // R11
  p_latch_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_DOWN || state_q == PS_INIT) |-> !act_en_q);
endmodule

// File: rtl/plink_enables.sv
module plink_enables
  import plink_pkg::*;
#(
  parameter logic [EN_W-1:0] MAP_DOWN   = 4'b0000,
  parameter logic [EN_W-1:0] MAP_INIT   = 4'b1100,
  parameter logic [EN_W-1:0] MAP_ARM    = 4'b1110,
  parameter logic [EN_W-1:0] MAP_ACTIVE = 4'b1111
)(
  input  logic            clk,
  input  logic            rst_n,
  input  pstate_e         state,
  output logic [EN_W-1:0] en
);
  // en bit order: [3] link, [2] mgmt, [1] data rx, [0] data tx
  for (genvar i = 0; i < EN_W; i++) begin : g_en
    always_comb begin
      unique case (state)
        PS_DOWN:   en[i] = MAP_DOWN[i];
        PS_INIT:   en[i] = MAP_INIT[i];
        PS_ARM:    en[i] = MAP_ARM[i];
        default:   en[i] = MAP_ACTIVE[i];
      endcase
    end
  end

  // R2
  p_tx_implies_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en[0] |-> (en[1] && en[2] && en[3]));
  // R2
  p_down_all_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == PS_DOWN |-> en == '0);
endmodule

// File: rtl/port_link_ctrl.sv
module port_link_ctrl
  import plink_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phy_up,
  input  logic [CMD_W-1:0] mgmt_cmd,
  input  logic             ev_remote_init,
  input  logic             ev_fc_normal,
  input  logic             ev_data_ok,
  input  logic             down_timeout,
  output logic [ST_W-1:0]  port_state,
  output logic             en_link_pkt,
  output logic             en_mgmt_pkt,
  output logic             en_data_tx,
  output logic             en_data_rx
);
  pstate_e         st;
  logic            act_en;
  logic [EN_W-1:0] en;

  plink_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .phy_up         (phy_up),
    .cmd            (mcmd_e'(mgmt_cmd)),
    .ev_remote_init (ev_remote_init),
    .ev_fc_normal   (ev_fc_normal),
    .ev_data_ok     (ev_data_ok),
    .down_timeout   (down_timeout),
    .state_q        (st),
    .act_en_q       (act_en)
  );

  plink_enables u_en (
    .clk   (clk),
    .rst_n (rst_n),
    .state (st),
    .en    (en)
  );

  assign port_state  = st;
  assign en_link_pkt = en[3];
  assign en_mgmt_pkt = en[2];
  assign en_data_rx  = en[1];
  assign en_data_tx  = en[0];

  // R10
  p_remote_init_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == PS_ARM || st == PS_ACTIVE) && ev_remote_init && phy_up &&
     mgmt_cmd != 2'b01 && !down_timeout) |=> port_state == 2'b01);
  // R7
  p_init_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PS_INIT && phy_up && mgmt_cmd != 2'b01 && mgmt_cmd != 2'b10 && !down_timeout)
    |=> port_state == 2'b01);
  wire unused_act = act_en;
endmodule

// File: tb/port_link_ctrl_tb_top.sv
`timescale 1ns/1ps
module port_link_ctrl_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       phy_up = 0;
  logic [1:0] mgmt_cmd = 0;
  logic       ev_remote_init = 0, ev_fc_normal = 0, ev_data_ok = 0, down_timeout = 0;
  logic [1:0] port_state;
  logic       en_link_pkt, en_mgmt_pkt, en_data_tx, en_data_rx;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  int m_state = 1;
  bit m_latch = 0;
  bit done = 0;

  always #10 clk = ~clk;

  port_link_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .phy_up(phy_up), .mgmt_cmd(mgmt_cmd),
    .ev_remote_init(ev_remote_init), .ev_fc_normal(ev_fc_normal),
    .ev_data_ok(ev_data_ok), .down_timeout(down_timeout),
    .port_state(port_state), .en_link_pkt(en_link_pkt), .en_mgmt_pkt(en_mgmt_pkt),
    .en_data_tx(en_data_tx), .en_data_rx(en_data_rx));

  // R2 enable table: {link, mgmt, rx, tx}
  function automatic logic [3:0] exp_en(int s);
    case (s)
      0: return 4'b0000;
      1: return 4'b1100;
      2: return 4'b1110;
      default: return 4'b1111;
    endcase
  endfunction

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 1; m_latch <= 0;
    end else begin
      int ns;
      bit nl;
      ns = m_state; nl = m_latch;
      if (!phy_up || mgmt_cmd == 2'd1 || down_timeout) ns = 0;
      else if (m_state == 0) ns = 1;
      else if (m_state == 1 && mgmt_cmd == 2'd2) ns = 2;
      else if (m_state >= 2 && ev_remote_init) ns = 1;
      else if (m_state == 2 && m_latch && ev_data_ok) ns = 3;
      if (m_state >= 2 && ev_fc_normal) nl = 1;
      if (ns < 2) nl = 0;
      m_state <= ns; m_latch <= nl;
    end
  end

  function automatic void cmp(int exp_s, string t);
    logic [3:0] got_en;
    got_en = {en_link_pkt, en_mgmt_pkt, en_data_rx, en_data_tx};
    checks++;
    if (port_state !== exp_s[1:0] || got_en !== exp_en(exp_s)) begin
      errors++;
      $display("FAIL %s state=%0d en=%b expected state=%0d en=%b",
               t, port_state, got_en, exp_s, exp_en(exp_s));
    end
  endfunction

  always @(posedge clk) begin
    #1;
    if (!done) cmp(m_state, {tag, " (model)"});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(bit phy, logic [1:0] c, bit ri, bit fc, bit dok, bit to, string t);
    @(negedge clk);
    phy_up = phy; mgmt_cmd = c; ev_remote_init = ri; ev_fc_normal = fc;
    ev_data_ok = dok; down_timeout = to; tag = t;
    @(posedge clk); #2;
  endtask

  task automatic expect_state(int s, string t);
    cmp(s, t);
  endtask

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #2 expect_state(1, "R1 in reset");
    @(negedge clk); phy_up = 1; rst_n = 1;
    step(1, 0, 0, 0, 0, 0, "R1");       expect_state(1, "R1 after release");
    // R7: events ignored in Initialize
    step(1, 0, 0, 1, 1, 0, "R7");       expect_state(1, "R7 events in Init");
    step(1, 0, 1, 0, 0, 0, "R7");       expect_state(1, "R7 remote init in Init");
    step(1, 3, 0, 0, 0, 0, "R7");       expect_state(1, "R7 Active cmd in Init");
    step(1, 2, 0, 0, 0, 0, "R7");       expect_state(2, "R7 Arm cmd");
    // R8 / R9
    step(1, 0, 0, 0, 1, 0, "R8");       expect_state(2, "R8 data without latch");
    step(1, 3, 0, 0, 0, 0, "R9");       expect_state(2, "R9 Active cmd alone");
    step(1, 0, 0, 1, 1, 0, "R8");       expect_state(2, "R8 same-cycle fc+data");
    step(1, 0, 0, 0, 1, 0, "R9");       expect_state(3, "R9 enter Active");
    // R10
    step(1, 0, 1, 0, 0, 0, "R10");      expect_state(1, "R10 Active to Init");
    // R11: latch cleared
    step(1, 2, 0, 0, 0, 0, "R11");      expect_state(2, "R11 re-arm");
    step(1, 0, 0, 0, 1, 0, "R11");      expect_state(2, "R11 stale latch");
    step(1, 0, 0, 1, 0, 0, "R11");      expect_state(2, "R11 set latch");
    step(1, 0, 1, 0, 0, 0, "R10");      expect_state(1, "R10 Arm to Init");
    step(1, 2, 0, 0, 0, 0, "R11");      expect_state(2, "R11 re-arm again");
    step(1, 0, 0, 0, 1, 0, "R11");      expect_state(2, "R11 latch lost");
    step(1, 0, 0, 1, 0, 0, "R9");       expect_state(2, "R9 latch");
    step(1, 0, 0, 0, 1, 0, "R9");       expect_state(3, "R9 Active");
    // R6 and R4
    step(1, 0, 0, 0, 0, 1, "R6");       expect_state(0, "R6 timeout");
    step(1, 0, 0, 0, 0, 1, "R6");       expect_state(0, "R6 timeout held");
    step(1, 0, 0, 0, 0, 0, "R4");       expect_state(1, "R4 Down to Init");
    // R5
    step(1, 1, 0, 0, 0, 0, "R5");       expect_state(0, "R5 Down cmd");
    step(1, 1, 0, 0, 0, 0, "R5");       expect_state(0, "R5 Down cmd held");
    step(1, 0, 0, 0, 0, 0, "R4");       expect_state(1, "R4 release");
    // R3
    step(0, 2, 0, 0, 0, 0, "R3");       expect_state(0, "R3 phy loss");
    step(0, 0, 0, 0, 0, 0, "R3");       expect_state(0, "R3 phy low stays");
    step(0, 0, 0, 0, 0, 0, "R3");       expect_state(0, "R3 phy low stays");
    step(1, 0, 1, 0, 0, 0, "R4");       expect_state(1, "R4 phy back");
    step(1, 2, 0, 0, 0, 0, "R3");
    step(1, 0, 0, 1, 0, 0, "R3");
    step(1, 0, 0, 0, 1, 0, "R3");       expect_state(3, "R3 setup Active");
    step(0, 0, 1, 0, 0, 0, "R3");       expect_state(0, "R3 priority over remote init");
    step(1, 0, 0, 0, 0, 0, "R2");       expect_state(1, "R2 Init map");
    // Weighted random stream compared with the model each cycle
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [1:0] c;
      r = $urandom_range(0, 99);
      c = (r < 6) ? 2'd1 : (r < 25) ? 2'd2 : (r < 35) ? 2'd3 : 2'd0;
      step($urandom_range(0, 99) > 3, c, $urandom_range(0, 99) < 5,
           $urandom_range(0, 99) < 20, $urandom_range(0, 99) < 25,
           $urandom_range(0, 99) < 3, "R2");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule